// File: doc/BRIEF.md
# Multi-Mode Operand Address Generator

This block produces operand addresses for a signal-processing datapath. It has its own small arithmetic path, so the main ALU does no address work. It keeps a current pointer, a step (offset) register and two buffer limit registers. On each cycle with a valid command, a 3-bit operation code selects how the next pointer is formed:

- hold the pointer;
- load a new value;
- step it by one in either direction;
- step it by the offset in either direction;
- step it by the signed offset and fold the result back into a circular region;
- advance it with a reverse-carry addition, which walks the index order that a radix-2 FFT needs.

The address is presented on a registered output, so one address is issued per cycle. A mode input chooses what that output carries. In post-modify mode it carries the pointer as it was before the update. In pre-modify mode it carries the updated pointer. Software or a sequencer fills the offset and limit registers through one write port. A value written there is seen by the next command, not the one in the same cycle. The load value may come from an immediate field, a general register or a memory read; the selection happens outside this block.

Top module: `agu_core`

## Requirements
- R1: After reset, `addr_o` is 0 and `addr_valid_o` is 0. The pointer, offset and both limit registers are 0.
- R2: Operation 3'b001 (load) with `op_valid` high sets the pointer to `load_val`.
- R3: Operation 3'b010 adds one to the pointer and 3'b011 subtracts one. Both wrap modulo 2^AW.
- R4: Operation 3'b100 adds the offset register to the pointer and 3'b101 subtracts it. Both wrap modulo 2^AW.
- R5: Operation 3'b110 reads the offset as two's complement and forms u = pointer + offset. Let lo be the lesser limit, hi the greater and size = hi - lo + 1. The new pointer is u - size if u > hi, u + size if u < lo, and u otherwise.
- R6: The circular step gives the same result whichever of the two limit registers holds the larger value.
- R7: Operation 3'b111 adds the offset to the pointer with the carry running from the most significant bit toward bit 0. The carry out of bit 0 is dropped. With offset 4 and a start of 0, the pointer walks 4, 2, 6, 1, 5, 3, 7, 0.
- R8: Operation 3'b000 with `op_valid` high leaves the pointer unchanged and presents it on `addr_o`.
- R9: In each valid cycle, `addr_o` on the next edge shows the updated pointer when `post_mode` is 0. It shows the pointer from before the update when `post_mode` is 1.
- R10: `addr_valid_o` equals `op_valid` one cycle later. While `op_valid` is low, the pointer and `addr_o` do not change.
- R11: `wr_en` with `wr_sel` 2'b00 writes the offset, 2'b01 the first limit, and 2'b10 the second limit; 2'b11 writes nothing. A command in the same cycle as the write uses the old register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Command strobe |
| op_code | input | 3 | Operation select |
| load_val | input | AW | Value for the load operation |
| post_mode | input | 1 | 1: output old pointer, 0: output new pointer |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | AW | Register write data |
| addr_o | output | AW | Registered operand address |
| addr_valid_o | output | 1 | Address valid, one cycle after `op_valid` |

## Verification
The assertions check the rules that tie one cycle to the next, on every cycle:
- the load, unit-step and hold updates of the pointer;
- which pointer value appears on the output in each modify mode;
- the delay from the command strobe to the valid flag;
- that nothing changes while no command is present.

The circular fold, the reverse-carry walk and the one-cycle delay before a register write is seen are shown only by the bench. It runs directed scenarios: an 8-point bit-reversed walk, wraps past either limit with the limits in both orders, and a write landing in the same cycle as a command. It then runs a seeded random stream compared against its own reference model.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [2:0] {
        OP_HOLD = 3'b000,
        OP_LOAD = 3'b001,
        OP_INC  = 3'b010,
        OP_DEC  = 3'b011,
        OP_ADDO = 3'b100,
        OP_SUBO = 3'b101,
        OP_CIRC = 3'b110,
        OP_BREV = 3'b111
    } agu_op_e;

    typedef enum logic [1:0] {
        SEL_OFF  = 2'b00,
        SEL_LIMA = 2'b01,
        SEL_LIMB = 2'b10,
        SEL_NONE = 2'b11
    } agu_sel_e;

endpackage

// File: rtl/agu_circ_wrap.sv
module agu_circ_wrap #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] lim_a,
    input  logic [AW-1:0] lim_b,
    output logic [AW-1:0] next
);
    localparam int EW = AW + 2;

    logic signed [EW-1:0] p_s, o_s, lo_s, hi_s, sz_s, u_s, w_s;
    logic                 unused_hi;

    always_comb begin
        p_s = {2'b00, ptr};
        o_s = {{2{step[AW-1]}}, step};
        if (lim_a <= lim_b) begin
            lo_s = {2'b00, lim_a};
            hi_s = {2'b00, lim_b};
        end else begin
            lo_s = {2'b00, lim_b};
            hi_s = {2'b00, lim_a};
        end
        sz_s = hi_s - lo_s + {{(EW-1){1'b0}}, 1'b1};
        u_s  = p_s + o_s;
        if (u_s > hi_s)
            w_s = u_s - sz_s;
        else if (u_s < lo_s)
            w_s = u_s + sz_s;
        else
            w_s = u_s;
    end

    assign next      = w_s[AW-1:0];
    assign unused_hi = ^w_s[EW-1:AW];
endmodule

// File: rtl/agu_revcarry.sv
module agu_revcarry #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] step,
    output logic [AW-1:0] sum
);
    logic [AW-1:0] rb_base, rb_step, rb_sum;

    for (genvar i = 0; i < AW; i++) begin : g_mirror
        assign rb_base[i] = base[AW-1-i];
        assign rb_step[i] = step[AW-1-i];
        assign sum[i]     = rb_sum[AW-1-i];
    end

    assign rb_sum = rb_base + rb_step;
endmodule

// File: rtl/agu_core.sv
module agu_core
    import agu_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [2:0]    op_code,
    input  logic [AW-1:0] load_val,
    input  logic          post_mode,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] addr_o,
    output logic          addr_valid_o
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] off;
        logic [AW-1:0] lim_a;
        logic [AW-1:0] lim_b;
        logic [AW-1:0] out;
        logic          vld;
    } agu_state_t;

    agu_state_t    st_d, st_q;
    logic [AW-1:0] circ_next, brev_next, new_addr;

    agu_circ_wrap #(.AW(AW)) u_circ (
        .ptr   (st_q.addr),
        .step  (st_q.off),
        .lim_a (st_q.lim_a),
        .lim_b (st_q.lim_b),
        .next  (circ_next)
    );

    agu_revcarry #(.AW(AW)) u_brev (
        .base (st_q.addr),
        .step (st_q.off),
        .sum  (brev_next)
    );

    always_comb begin
        st_d = st_q;
        unique case (agu_op_e'(op_code))
            OP_HOLD: new_addr = st_q.addr;
            OP_LOAD: new_addr = load_val;
            OP_INC:  new_addr = st_q.addr + ONE;
            OP_DEC:  new_addr = st_q.addr - ONE;
            OP_ADDO: new_addr = st_q.addr + st_q.off;
            OP_SUBO: new_addr = st_q.addr - st_q.off;
            OP_CIRC: new_addr = circ_next;
            OP_BREV: new_addr = brev_next;
            default: new_addr = st_q.addr;
        endcase
        if (op_valid) begin
            st_d.addr = new_addr;
            st_d.out  = post_mode ? st_q.addr : new_addr;
        end
        st_d.vld = op_valid;
        if (wr_en) begin
            unique case (agu_sel_e'(wr_sel))
                SEL_OFF:  st_d.off   = wr_data;
                SEL_LIMA: st_d.lim_a = wr_data;
                SEL_LIMB: st_d.lim_b = wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign addr_o       = st_q.out;
    assign addr_valid_o = st_q.vld;
endmodule

// File: rtl/agu_core_chk.sv
module agu_core_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [2:0]    op_code,
    input logic [AW-1:0] load_val,
    input logic          post_mode,
    input logic [AW-1:0] addr_o,
    input logic          addr_valid_o,
    input logic [AW-1:0] cur_addr
);
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'b001) |=> cur_addr == $past(load_val));

    p_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'b010) |=> cur_addr == $past(cur_addr) + 1'b1);

    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'b011) |=> cur_addr == $past(cur_addr) - 1'b1);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'b000) |=> $stable(cur_addr));

    p_post_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && post_mode) |=> addr_o == $past(cur_addr));

    p_pre_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !post_mode) |=> addr_o == cur_addr);

    p_vld_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> addr_valid_o);

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!addr_valid_o && $stable(cur_addr) && $stable(addr_o)));
endmodule

bind agu_core agu_core_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_code      (op_code),
    .load_val     (load_val),
    .post_mode    (post_mode),
    .addr_o       (addr_o),
    .addr_valid_o (addr_valid_o),
    .cur_addr     (st_q.addr)
);

// File: tb/agu_core_test.sv
`timescale 1ns/1ps
module agu_core_test;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [2:0]    op_code = 3'b000;
    logic [AW-1:0] load_val = '0;
    logic          post_mode = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'b00;
    logic [AW-1:0] wr_data = '0;
    logic [AW-1:0] addr_o;
    logic          addr_valid_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [AW-1:0] m_addr = '0, m_off = '0, m_la = '0, m_lb = '0, m_out = '0;
    logic          m_vld = 1'b0;

    always #2 clk = ~clk;

    agu_core #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .load_val(load_val), .post_mode(post_mode), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .addr_o(addr_o),
        .addr_valid_o(addr_valid_o)
    );

    function automatic logic [AW-1:0] f_circ(logic [AW-1:0] p, logic [AW-1:0] o,
                                             logic [AW-1:0] a, logic [AW-1:0] b);
        int lo, hi, sz, u;
        lo = (a < b) ? int'(a) : int'(b);
        hi = (a < b) ? int'(b) : int'(a);
        sz = hi - lo + 1;
        u  = int'(p) + int'($signed(o));
        if (u > hi) u = u - sz;
        else if (u < lo) u = u + sz;
        return u[AW-1:0];
    endfunction

    function automatic logic [AW-1:0] f_rev(logic [AW-1:0] a, logic [AW-1:0] b);
        logic [AW-1:0] s;
        logic c;
        c = 1'b0;
        for (int i = AW - 1; i >= 0; i--) begin
            s[i] = a[i] ^ b[i] ^ c;
            c = (a[i] & b[i]) | (a[i] & c) | (b[i] & c);
        end
        return s;
    endfunction

    function automatic logic [AW-1:0] f_next(logic [2:0] op, logic [AW-1:0] lv);
        case (op)
            3'b001: return lv;
            3'b010: return m_addr + 1'b1;
            3'b011: return m_addr - 1'b1;
            3'b100: return m_addr + m_off;
            3'b101: return m_addr - m_off;
            3'b110: return f_circ(m_addr, m_off, m_la, m_lb);
            3'b111: return f_rev(m_addr, m_off);
            default: return m_addr;
        endcase
    endfunction

    task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp,
                         input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [2:0] op, input logic [AW-1:0] lv,
                        input logic pm, input logic we, input logic [1:0] ws,
                        input logic [AW-1:0] wd, input string tag);
        logic [AW-1:0] nx;
        op_valid = v; op_code = op; load_val = lv; post_mode = pm;
        wr_en = we; wr_sel = ws; wr_data = wd;
        nx = f_next(op, lv);
        @(posedge clk);
        if (v) begin
            m_out  = pm ? m_addr : nx;
            m_addr = nx;
        end
        m_vld = v;
        if (we) begin
            case (ws)
                2'b00: m_off = wd;
                2'b01: m_la = wd;
                2'b10: m_lb = wd;
                default: ;
            endcase
        end
        @(negedge clk);
        check(addr_o, m_out, tag);
        check({{(AW-1){1'b0}}, addr_valid_o}, {{(AW-1){1'b0}}, m_vld}, "R10 valid");
    endtask

    task automatic wr(input logic [1:0] ws, input logic [AW-1:0] wd);
        step(1'b0, 3'b000, '0, 1'b0, 1'b1, ws, wd, "R11 write");
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(addr_o, '0, "R1 addr reset");
        check({{(AW-1){1'b0}}, addr_valid_o}, '0, "R1 valid reset");
        step(1'b1, 3'b100, '0, 1'b0, 1'b0, 2'b00, '0, "R1 zero offset");
        check(addr_o, 16'h0000, "R1 offset is zero");
        step(1'b1, 3'b010, '0, 1'b0, 1'b0, 2'b00, '0, "R3 inc");
        check(addr_o, 16'h0001, "R3 inc literal");
        step(1'b1, 3'b011, '0, 1'b0, 1'b0, 2'b00, '0, "R3 dec");
        step(1'b1, 3'b011, '0, 1'b0, 1'b0, 2'b00, '0, "R3 dec wrap");
        check(addr_o, 16'hFFFF, "R3 dec wrap literal");
        step(1'b1, 3'b001, 16'h1234, 1'b1, 1'b0, 2'b00, '0, "R9 post load");
        check(addr_o, 16'hFFFF, "R9 post shows old");
        step(1'b1, 3'b000, '0, 1'b0, 1'b0, 2'b00, '0, "R8 hold");
        check(addr_o, 16'h1234, "R2 R8 loaded and held");
        // R11: offset write and add in the same cycle use the old offset (0)
        step(1'b1, 3'b100, '0, 1'b0, 1'b1, 2'b00, 16'h0003, "R11 same cycle");
        check(addr_o, 16'h1234, "R11 old offset used");
        step(1'b1, 3'b100, '0, 1'b0, 1'b0, 2'b00, '0, "R4 add");
        check(addr_o, 16'h1237, "R4 add literal");
        step(1'b1, 3'b101, '0, 1'b0, 1'b1, 2'b11, 16'hBEEF, "R4 sub");
        check(addr_o, 16'h1234, "R4 R11 sub, sel 3 ignored");
        step(1'b0, 3'b010, '0, 1'b0, 1'b0, 2'b00, '0, "R10 idle");
        check(addr_o, 16'h1234, "R10 idle holds");
        // R5: circular 0x100..0x107
        wr(2'b01, 16'h0100); wr(2'b10, 16'h0107);
        step(1'b1, 3'b001, 16'h0106, 1'b0, 1'b0, 2'b00, '0, "R2 load");
        step(1'b1, 3'b110, '0, 1'b0, 1'b0, 2'b00, '0, "R5 circ up");
        check(addr_o, 16'h0101, "R5 wrap above end");
        wr(2'b00, 16'hFFFD);
        step(1'b1, 3'b110, '0, 1'b0, 1'b0, 2'b00, '0, "R5 circ down");
        check(addr_o, 16'h0106, "R5 wrap below start");
        // R6: swapped limits
        wr(2'b01, 16'h0107); wr(2'b10, 16'h0100); wr(2'b00, 16'h0003);
        step(1'b1, 3'b110, '0, 1'b0, 1'b0, 2'b00, '0, "R6 circ swapped");
        check(addr_o, 16'h0101, "R6 swapped limits wrap");
        // R7: 8-point bit reversed walk
        wr(2'b00, 16'h0004);
        step(1'b1, 3'b001, 16'h0000, 1'b0, 1'b0, 2'b00, '0, "R2 load zero");
        for (int k = 0; k < 8; k++) begin
            logic [AW-1:0] want;
            step(1'b1, 3'b111, '0, 1'b0, 1'b0, 2'b00, '0, "R7 brev");
            case (k)
                0: want = 4; 1: want = 2; 2: want = 6; 3: want = 1;
                4: want = 5; 5: want = 3; 6: want = 7; default: want = 0;
            endcase
            check(addr_o, want, "R7 brev order");
        end
        // random phase, all requirements against model
        for (int n = 0; n < 400; n++) begin
            step(($urandom % 5) != 0, 3'($urandom), 16'($urandom), 1'($urandom),
                 ($urandom % 4) == 0, 2'($urandom), 16'($urandom), "R2-R11 random");
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule